// File: doc/BRIEF.md
# Three-Stage Sigma-Delta Error-Cancellation Combiner

This block is the digital back end of a 2-1-1 cascaded sigma-delta modulator. Each of the three analog stages produces a one-bit quantizer decision per sampling period, and all three decisions arrive together under one shared sample strobe. The combiner passes each stage's stream through its own fixed polynomial filter and adds the three branch results into one signed word. The quantization errors of the first two stages cancel in this sum. The third stage's error remains, shaped to fourth order.

Stage one's filter has a denominator of 48. To keep the arithmetic in integers, every branch weight is multiplied by 48, so the output word equals 48 times the ideal combined value. Each one-bit decision is treated as +1 or −1. The sum is registered on every strobe. A valid pulse marks outputs whose filter windows hold only real samples. A decimation filter normally follows the block, running at the modulator rate.

Top module: `sdc_combiner`

## Requirements
- R1: A stage input bit of 1 counts as +1 and a bit of 0 counts as −1 in every branch product.
- R2: The stage-one branch, scaled by 48, applies weights 0, 7, 29, −7, −5 to that stage's samples with delays 0, 1, 2, 3, 4 strobes.
- R3: The stage-two branch, scaled by 48, applies weights 0, 48, −48, −48, 48 to delays 0 through 4.
- R4: The stage-three branch, scaled by 48, applies weights 96, −288, 288, −96 to delays 0 through 3.
- R5: While reset is high at a clock edge, the output word becomes 0, the valid flag becomes 0, and every stored past sample becomes the −1 level.
- R6: The output word takes the new sum (R2 + R3 + R4) exactly one clock after a strobe cycle. The valid flag is high only in the cycle after a strobe.
- R7: In cycles without a strobe, input bits are ignored, the stored history does not advance, and the output word holds its value.
- R8: After reset, the first four strobes produce no valid pulse. Every strobe from the fifth onward produces one.
- R9: When reset and a strobe occur in the same cycle, reset wins and the strobe counts neither as a sample nor toward priming.
- R10: The output is an 11-bit two's-complement word whose magnitude never exceeds 1008.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_en | input | 1 | Sample strobe shared by all three stages |
| bit_s1 | input | 1 | Stage-one quantizer decision |
| bit_s2 | input | 1 | Stage-two quantizer decision |
| bit_s3 | input | 1 | Stage-three quantizer decision |
| sum_out | output | 11 | Registered combined word, scaled by 48 |
| sum_vld | output | 1 | One-cycle pulse marking a primed output |

## Verification
Two functions can land in the same cycle: clearing the pipeline on reset and loading a sample on a strobe. The bench raises both together. It then judges the result at the ports: the output must read zero, and the next four strobes must give no valid pulse. All following sums must match a model whose history was filled with −1 and never saw the colliding sample. A second overlap, where the fifth strobe both loads data and first asserts valid, is checked on every priming sequence.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  localparam int NSTAGE = 3;
  localparam int MAXTAP = 5;

  // number of taps (delays 0..n-1) per stage, stages counted from 0
  function automatic int tap_count(input int s);
    case (s)
      0:       return 5;
      1:       return 5;
      default: return 4;
    endcase
  endfunction

  // weights already scaled by 48
  function automatic int tap_w(input int s, input int k);
    int w;
    w = 0;
    case (s)
      0: case (k) 1: w = 7;   2: w = 29;   3: w = -7;  4: w = -5; default: w = 0; endcase
      1: case (k) 1: w = 48;  2: w = -48;  3: w = -48; 4: w = 48; default: w = 0; endcase
      default: case (k) 0: w = 96; 1: w = -288; 2: w = 288; 3: w = -96; default: w = 0; endcase
    endcase
    return w;
  endfunction

  function automatic int peak_mag();
    int p;
    p = 0;
    for (int s = 0; s < NSTAGE; s++)
      for (int k = 0; k < MAXTAP; k++)
        p += (tap_w(s, k) < 0) ? -tap_w(s, k) : tap_w(s, k);
    return p;
  endfunction
endpackage

// File: rtl/sdc_history.sv
module sdc_history #(
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             din,
  output logic [DEPTH-1:0] hist
);
  // hist[0] is the sample one strobe old; bit 0 encodes the -1 level
  generate
    if (DEPTH == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst)     hist <= '0;
        else if (en) hist <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst)     hist <= '0;
        else if (en) hist <= {hist[DEPTH-2:0], din};
      end
    end
  endgenerate

  a_r5_hist_clear: assert property (@(posedge clk) rst |=> hist == '0);
  a_r7_hist_frozen: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(hist));
  a_r2_hist_newest: assert property (@(posedge clk) disable iff (rst)
    en |=> hist[0] == $past(din));
endmodule

// File: rtl/sdc_branch.sv
module sdc_branch #(
  parameter int STAGE = 0,
  parameter int HD    = 4,
  parameter int ACC_W = 11
) (
  input  logic                    cur,
  input  logic [HD-1:0]           past,
  output logic signed [ACC_W-1:0] acc
);
  localparam int WIN = HD + 1;
  logic [WIN-1:0] win;
  assign win = {past, cur};

  always_comb begin
    int s;
    s = 0;
    for (int k = 0; k < WIN; k++) begin
      if (win[k]) s += sdc_pkg::tap_w(STAGE, k);
      else        s -= sdc_pkg::tap_w(STAGE, k);
    end
    acc = ACC_W'(s);
  end
endmodule

// File: rtl/sdc_combiner.sv
module sdc_combiner #(
  parameter int OUT_W = 11
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    smp_en,
  input  logic                    bit_s1,
  input  logic                    bit_s2,
  input  logic                    bit_s3,
  output logic signed [OUT_W-1:0] sum_out,
  output logic                    sum_vld
);
  localparam int NST   = sdc_pkg::NSTAGE;
  localparam int PRIME = sdc_pkg::MAXTAP - 1;
  localparam int CNT_W = $clog2(PRIME + 1);
  localparam int PEAK  = sdc_pkg::peak_mag();

  logic [NST-1:0]          bits;
  logic signed [OUT_W-1:0] br_sum [NST];
  logic signed [OUT_W-1:0] total;
  logic [CNT_W-1:0]        cnt;

  assign bits = {bit_s3, bit_s2, bit_s1};

  for (genvar g = 0; g < NST; g++) begin : g_stage
    localparam int HD = sdc_pkg::tap_count(g) - 1;
    logic [HD-1:0] past;

    sdc_history #(.DEPTH(HD)) u_hist (
      .clk(clk), .rst(rst), .en(smp_en), .din(bits[g]), .hist(past)
    );
    sdc_branch #(.STAGE(g), .HD(HD), .ACC_W(OUT_W)) u_br (
      .cur(bits[g]), .past(past), .acc(br_sum[g])
    );
  end

  always_comb begin
    total = '0;
    for (int g = 0; g < NST; g++) total = total + br_sum[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_out <= '0;
      sum_vld <= 1'b0;
      cnt     <= '0;
    end else begin
      sum_vld <= smp_en && (cnt == CNT_W'(PRIME));
      if (smp_en) begin
        sum_out <= total;
        if (cnt != CNT_W'(PRIME)) cnt <= cnt + 1'b1;
      end
    end
  end

  a_r5_reset_out: assert property (@(posedge clk)
    rst |=> (sum_out == '0 && !sum_vld));
  a_r9_reset_wins: assert property (@(posedge clk)
    (rst && smp_en) |=> !sum_vld);
  a_r6_vld_after_strobe: assert property (@(posedge clk) disable iff (rst)
    sum_vld |-> $past(smp_en));
  a_r7_out_hold: assert property (@(posedge clk) disable iff (rst)
    !smp_en |=> $stable(sum_out));
  a_r8_no_early_vld: assert property (@(posedge clk) disable iff (rst)
    (smp_en && cnt < CNT_W'(PRIME)) |=> !sum_vld);
  a_r10_range: assert property (@(posedge clk) disable iff (rst)
    ($signed(sum_out) <= PEAK && $signed(sum_out) >= -PEAK));
endmodule

// File: tb/sdc_combiner_test.sv
module sdc_combiner_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_en = 1'b0;
  logic bit_s1 = 1'b0, bit_s2 = 1'b0, bit_s3 = 1'b0;
  logic signed [10:0] sum_out;
  logic sum_vld;

  int total = 0;
  int bad = 0;
  int hist [3][4];
  int nsamp = 0;
  int exp_out = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_P/2) clk = ~clk;

  sdc_combiner uut (
    .clk(clk), .rst(rst), .smp_en(smp_en),
    .bit_s1(bit_s1), .bit_s2(bit_s2), .bit_s3(bit_s3),
    .sum_out(sum_out), .sum_vld(sum_vld)
  );

  function automatic int wt(input int s, input int k);
    int t1 [5] = '{0, 7, 29, -7, -5};
    int t2 [5] = '{0, 48, -48, -48, 48};
    int t3 [5] = '{96, -288, 288, -96, 0};
    if (s == 0) return t1[k];
    if (s == 1) return t2[k];
    return t3[k];
  endfunction

  task automatic chk(input int act, input int exp, input string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int s = 0; s < 3; s++)
      for (int k = 0; k < 4; k++) hist[s][k] = -1;
    nsamp = 0;
    exp_out = 0;
  endtask

  // strobe one sample triple, then idle for gap cycles with scrambled inputs
  task automatic strobe(input logic [2:0] b, input int gap, input string tag);
    int v [3];
    int e;
    int ev;
    @(negedge clk);
    smp_en = 1'b1;
    bit_s1 = b[0]; bit_s2 = b[1]; bit_s3 = b[2];
    for (int s = 0; s < 3; s++) v[s] = b[s] ? 1 : -1;   // R1 mapping
    e = 0;
    for (int s = 0; s < 3; s++) begin
      e += wt(s, 0) * v[s];
      for (int k = 1; k < 5; k++) e += wt(s, k) * hist[s][k-1];
    end
    for (int s = 0; s < 3; s++) begin
      for (int k = 3; k > 0; k--) hist[s][k] = hist[s][k-1];
      hist[s][0] = v[s];
    end
    ev = (nsamp >= 4) ? 1 : 0;
    if (nsamp < 4) nsamp++;
    exp_out = e;
    @(negedge clk);
    smp_en = 1'b0;
    bit_s1 = ~b[0]; bit_s2 = ~b[1]; bit_s3 = ~b[2];
    chk(int'(sum_out), e, tag);
    chk(int'(sum_vld), ev, "R6 R8 valid after strobe");
    if (sum_out > 11'sd1008 || sum_out < -11'sd1008) chk(int'(sum_out), 1008, "R10 range");
    for (int i = 0; i < gap; i++) begin
      @(negedge clk);
      bit_s1 = ~bit_s1; bit_s3 = ~bit_s3;
      chk(int'(sum_out), exp_out, "R7 hold between strobes");
      chk(int'(sum_vld), 0, "R6 valid only after strobe");
    end
  endtask

  task automatic do_reset(input logic with_strobe);
    @(negedge clk);
    rst = 1'b1;
    smp_en = with_strobe;
    bit_s1 = 1'b1; bit_s2 = 1'b1; bit_s3 = 1'b1;
    @(negedge clk);
    chk(int'(sum_out), 0, with_strobe ? "R9 reset beats strobe, output" : "R5 reset output");
    chk(int'(sum_vld), 0, with_strobe ? "R9 reset beats strobe, valid" : "R5 reset valid");
    rst = 1'b0;
    smp_en = 1'b0;
    model_clear();
  endtask

  function automatic logic [2:0] next_rand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[2:0];
  endfunction

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    do_reset(1'b0);
    // R5: first primed output from an all -1 history; checked inside strobe
    strobe(3'b000, 0, "R5 R1 all low from cleared history");

    // R2: only stage one toggles, other stages held at 1
    for (int i = 0; i < 32; i++) strobe({2'b11, i[0] ^ i[2]}, i % 2, "R2 stage one weights");
    // R3: only stage two toggles
    for (int i = 0; i < 32; i++) strobe({1'b0, i[1] ^ i[0], 1'b0}, 0, "R3 stage two weights");
    // R4: only stage three toggles
    for (int i = 0; i < 32; i++) strobe({i[0] | i[2], 2'b01}, 1, "R4 stage three weights");

    // R9: reset with simultaneous strobe, then priming must restart
    do_reset(1'b1);
    for (int i = 0; i < 6; i++) strobe(3'b111, 0, "R9 R8 priming after collided reset");

    // near-exhaustive sweep over all 8 input triples in pseudo-random order
    for (int i = 0; i < 6000; i++) strobe(next_rand(), int'(lfsr[4:3]) % 3, "R1 R2 R3 R4 sweep");

    // extreme patterns for R10
    do_reset(1'b0);
    for (int i = 0; i < 24; i++) strobe((i % 2 == 0) ? 3'b111 : 3'b000, 0, "R10 alternating extremes");
    for (int i = 0; i < 24; i++) strobe(((i / 2) % 2 == 0) ? 3'b101 : 3'b010, 0, "R10 paired extremes");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule